// File: doc/BRIEF.md
# Host Request Controller

This block sits on the host side of a processor's parallel host port. It holds an 8-bit control register that the host writes, and it drives one active-low request line back to the host. It also tracks two one-entry buffer states. The transmit-empty state says the host may write the next transmit word. The receive-full state says a word waits for the host to read. The processor side changes these states with single-cycle pulses, and the host's own data strobes change them too.

The one request line serves two uses. In interrupt use, each buffer state has its own enable bit. In DMA use, a direction bit picks which buffer state raises the request, and the enable bits play no part. The host starts an initialization by writing a self-clearing bit. The enables and direction written in that same write take effect. The block then stays busy for a fixed number of cycles. Data strobes and control writes that arrive while it is busy are dropped and recorded in a sticky flag. When the busy window ends, the transmit buffer is marked empty and the receive buffer is marked not full. The request line then shows the host that it may begin transfers.

Top module: `hreq_ctrl`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x00, `hreq_n` is 1, and both `acc_viol` and `cfg_err` are 0.
- R2: The control bits sit at these positions: bit 0 is the receive request enable, bit 1 is the DMA direction (1 = host to device), bit 2 is the DMA enable and bit 5 is the transmit request enable. The status bits sit at these positions: bit 3 is transmit-empty, bit 4 is receive-full and bit 6 is init-busy. Bit 7 reads 0. Writes to bits 3, 4 and 7 have no effect.
- R3: A control write with bit 2 and bit 5 both set is rejected as a whole and leaves the register unchanged. It also sets the sticky `cfg_err` on the next cycle.
- R4: A control write with bit 6 set, made while not busy, loads the other control bits from that same write. Bit 6 then reads 1 for exactly INIT_CYCLES cycles and reads 0 afterwards. `hreq_n` stays 1 throughout the busy window.
- R5: At the end of the busy window, transmit-empty becomes 1 and receive-full becomes 0.
- R6: While busy, a `tx_wr`, an `rx_rd` or a `ctl_wr` is ignored and sets the sticky `acc_viol` on the next cycle. `acc_viol` stays set until reset.
- R7: When DMA is off, the request is active exactly when (bit 5 and transmit-empty) or (bit 0 and receive-full) holds.
- R8: When DMA is on, the request equals transmit-empty if bit 1 is 1 and equals receive-full if bit 1 is 0. Bits 0 and 5 have no effect on it.
- R9: `hreq_n` is a registered, active-low output. It reflects the request condition one cycle after the state that causes it.
- R10: Outside the busy window, `tx_wr` clears transmit-empty, `tx_drain` sets it, and a `tx_wr` together with a `tx_drain` leaves it 0. `rx_load` sets receive-full, `rx_rd` clears it, and an `rx_load` together with an `rx_rd` leaves it 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Host write strobe for the control register |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control and status read value |
| tx_wr | input | 1 | Host writes the transmit data register |
| rx_rd | input | 1 | Host reads the receive data register |
| tx_drain | input | 1 | Processor side has taken the transmit word |
| rx_load | input | 1 | Processor side has placed a receive word |
| hreq_n | output | 1 | Active-low host request |
| acc_viol | output | 1 | Sticky flag for an access made during initialization |
| cfg_err | output | 1 | Sticky flag for a rejected DMA plus transmit-enable write |

## Verification
Two updates can land on the same buffer state in one cycle. On the transmit side, the host's data strobe can meet the processor's drain pulse. On the receive side, the processor's load pulse can meet the host's read. The bench raises both strobes of a pair in the same cycle. It reads the status bit back on the next cycle: transmit-empty must be 0 and receive-full must be 1. It also checks the request line one cycle later. The initialization write is checked in the same way. It carries enable bits along with it, and a host strobe is placed inside the busy window. The sticky violation flag must rise, while the flags left at the end of initialization must not be affected by that strobe.

// File: rtl/hreq_pkg.sv
`timescale 1ns/1ps
package hreq_pkg;
  localparam int CTL_W     = 8;
  localparam int BIT_RXIE  = 0;
  localparam int BIT_DIR   = 1;
  localparam int BIT_DMA   = 2;
  localparam int BIT_TXE   = 3;
  localparam int BIT_RXF   = 4;
  localparam int BIT_TXIE  = 5;
  localparam int BIT_INIT  = 6;

  typedef struct packed {
    logic txie;
    logic dma;
    logic dir;
    logic rxie;
  } hreq_cfg_t;

  // DMA together with transmit interrupt enable is not a legal setting
  function automatic logic cfg_conflict(input logic [CTL_W-1:0] w);
    return w[BIT_DMA] & w[BIT_TXIE];
  endfunction

  function automatic hreq_cfg_t cfg_unpack(input logic [CTL_W-1:0] w);
    hreq_cfg_t c;
    c.txie = w[BIT_TXIE];
    c.dma  = w[BIT_DMA];
    c.dir  = w[BIT_DIR];
    c.rxie = w[BIT_RXIE];
    return c;
  endfunction

  function automatic logic [CTL_W-1:0] status_pack(input hreq_cfg_t c, input logic txe,
                                                   input logic rxf, input logic busy);
    logic [CTL_W-1:0] r;
    r = '0;
    r[BIT_RXIE] = c.rxie;
    r[BIT_DIR]  = c.dir;
    r[BIT_DMA]  = c.dma;
    r[BIT_TXE]  = txe;
    r[BIT_RXF]  = rxf;
    r[BIT_TXIE] = c.txie;
    r[BIT_INIT] = busy;
    return r;
  endfunction

  // Request condition, active high
  function automatic logic req_eval(input hreq_cfg_t c, input logic txe,
                                    input logic rxf, input logic busy);
    logic r;
    if (busy)       r = 1'b0;
    else if (c.dma) r = c.dir ? txe : rxf;
    else            r = (c.txie & txe) | (c.rxie & rxf);
    return r;
  endfunction

  // Host write fills, processor drain empties; both at once leaves it full
  function automatic logic tx_next(input logic cur, input logic wr, input logic drain);
    return (cur | drain) & ~wr;
  endfunction

  // Processor load fills, host read empties; both at once leaves it full
  function automatic logic rx_next(input logic cur, input logic rd, input logic load);
    return (cur & ~rd) | load;
  endfunction
endpackage

// File: rtl/hreq_cfg_reg.sv
`timescale 1ns/1ps
module hreq_cfg_reg import hreq_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             busy,
  output hreq_cfg_t        cfg,
  output logic             init_start,
  output logic             cfg_err
);
  logic conflict_w;
  logic wr_ok_w;

  assign conflict_w = cfg_conflict(ctl_wdata);
  assign wr_ok_w    = ctl_wr && !busy && !conflict_w;
  assign init_start = wr_ok_w && ctl_wdata[BIT_INIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '0;
      cfg_err <= 1'b0;
    end else begin
      if (wr_ok_w) cfg <= cfg_unpack(ctl_wdata);
      if (ctl_wr && !busy && conflict_w) cfg_err <= 1'b1;
    end
  end

  assert_conflict_rejected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !busy && ctl_wdata[BIT_DMA] && ctl_wdata[BIT_TXIE]) |=> (cfg_err && $stable(cfg)));

  assert_busy_locks_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg));

  assert_cfg_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: rtl/hreq_init_seq.sv
`timescale 1ns/1ps
module hreq_init_seq #(
  parameter int INIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic init_done
);
  localparam int CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;

  logic [CW-1:0] cnt;

  assign init_done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(INIT_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  // Checker counter for the length of the busy window
  int chk_len;
  always_ff @(posedge clk) begin
    if (!rst_n)                chk_len <= 0;
    else if (start)            chk_len <= 1;
    else if (busy && !init_done) chk_len <= chk_len + 1;
  end

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  assert_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_len == INIT_CYCLES));
endmodule

// File: rtl/hreq_flags.sv
`timescale 1ns/1ps
module hreq_flags import hreq_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic init_done,
  input  logic tx_wr,
  input  logic rx_rd,
  input  logic tx_drain,
  input  logic rx_load,
  input  logic ctl_wr,
  output logic tx_empty,
  output logic rx_full,
  output logic acc_viol
);
  logic bad_access_w;

  assign bad_access_w = busy && (tx_wr || rx_rd || ctl_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_empty <= 1'b0;
      rx_full  <= 1'b0;
      acc_viol <= 1'b0;
    end else begin
      if (init_done) begin
        tx_empty <= 1'b1;
        rx_full  <= 1'b0;
      end else if (!busy) begin
        tx_empty <= tx_next(tx_empty, tx_wr, tx_drain);
        rx_full  <= rx_next(rx_full, rx_rd, rx_load);
      end
      if (bad_access_w) acc_viol <= 1'b1;
    end
  end

  assert_init_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (tx_empty && !rx_full));

  assert_tx_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tx_wr) |=> !tx_empty);

  assert_rx_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rx_load) |=> rx_full);

  assert_viol_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_wr) |=> acc_viol);

  assert_viol_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_viol |=> acc_viol);
endmodule

// File: rtl/hreq_drive.sv
`timescale 1ns/1ps
module hreq_drive import hreq_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  hreq_cfg_t cfg,
  input  logic      tx_empty,
  input  logic      rx_full,
  input  logic      busy,
  output logic      hreq_n
);
  logic req_w;

  assign req_w = req_eval(cfg, tx_empty, rx_full, busy);

  always_ff @(posedge clk) begin
    if (!rst_n) hreq_n <= 1'b1;
    else        hreq_n <= ~req_w;
  end

  assert_busy_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> hreq_n);

  assert_dma_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg.dma && cfg.dir && tx_empty) |=> !hreq_n);

  assert_dma_rx_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.dma && !cfg.dir && !rx_full) |=> hreq_n);

  assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.dma && !cfg.txie && !cfg.rxie) |=> hreq_n);
endmodule

// File: rtl/hreq_ctrl.sv
`timescale 1ns/1ps
module hreq_ctrl import hreq_pkg::*; #(
  parameter int INIT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       tx_wr,
  input  logic       rx_rd,
  input  logic       tx_drain,
  input  logic       rx_load,
  output logic       hreq_n,
  output logic       acc_viol,
  output logic       cfg_err
);
  hreq_cfg_t cfg;
  logic      init_start;
  logic      busy;
  logic      init_done;
  logic      tx_empty;
  logic      rx_full;

  hreq_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .busy       (busy),
    .cfg        (cfg),
    .init_start (init_start),
    .cfg_err    (cfg_err)
  );

  hreq_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (init_start),
    .busy      (busy),
    .init_done (init_done)
  );

  hreq_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .init_done (init_done),
    .tx_wr     (tx_wr),
    .rx_rd     (rx_rd),
    .tx_drain  (tx_drain),
    .rx_load   (rx_load),
    .ctl_wr    (ctl_wr),
    .tx_empty  (tx_empty),
    .rx_full   (rx_full),
    .acc_viol  (acc_viol)
  );

  hreq_drive u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .busy     (busy),
    .hreq_n   (hreq_n)
  );

  assign ctl_rdata = status_pack(cfg, tx_empty, rx_full, busy);

  assert_rd_bit7_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7] == 1'b0);
endmodule

// File: tb/hreq_ctrl_bench.sv
`timescale 1ns/1ps
module hreq_ctrl_bench;
  localparam int N = 4;
  localparam int K_RD = 0, K_HREQ = 1, K_VIOL = 2, K_CERR = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       tx_wr = 1'b0, rx_rd = 1'b0, tx_drain = 1'b0, rx_load = 1'b0;
  logic       hreq_n, acc_viol, cfg_err;

  hreq_ctrl #(.INIT_CYCLES(N)) u_hreq_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .tx_wr(tx_wr), .rx_rd(rx_rd), .tx_drain(tx_drain),
    .rx_load(rx_load), .hreq_n(hreq_n), .acc_viol(acc_viol), .cfg_err(cfg_err)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int kind; logic [7:0] val; int rq; } item_t;
  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic expect_at(input int due, input int kind, input logic [7:0] val, input int rq);
    item_t it;
    it.due = due; it.kind = kind; it.val = val; it.rq = rq;
    sb.push_back(it);
  endtask

  // Monitor: compare every item that falls due in this cycle
  initial begin
    forever begin
      @(negedge clk); #0.2;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due <= cyc) begin
          logic [7:0] act;
          case (sb[i].kind)
            K_RD:    act = ctl_rdata;
            K_HREQ:  act = {7'd0, hreq_n};
            K_VIOL:  act = {7'd0, acc_viol};
            default: act = {7'd0, cfg_err};
          endcase
          checks++;
          if (act !== sb[i].val) begin
            fails++;
            $display("FAIL R%0d kind %0d cycle %0d: actual %h expected %h",
                     sb[i].rq, sb[i].kind, cyc, act, sb[i].val);
          end
          sb.delete(i);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk); #0.5;
  endtask

  task automatic idle();
    ctl_wr = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; tx_drain = 1'b0; rx_load = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) step();
  endtask

  // Drive one single-cycle stimulus and return its cycle
  task automatic pulse_ctl(input logic [7:0] d, output int c);
    step(); c = cyc; ctl_wr = 1'b1; ctl_wdata = d;
  endtask

  initial begin
    int c;
    idle();
    repeat (3) step();
    rst_n = 1'b1;
    c = cyc;
    // R1 reset state
    expect_at(c + 1, K_RD, 8'h00, 1);
    expect_at(c + 1, K_HREQ, 8'h01, 1);
    expect_at(c + 1, K_VIOL, 8'h00, 1);
    expect_at(c + 1, K_CERR, 8'h00, 1);
    step(); step();

    // R4: init together with transmit enable
    pulse_ctl(8'h60, c);
    expect_at(c + 1, K_RD, 8'h60, 4);
    expect_at(c + 2, K_HREQ, 8'h01, 4);
    expect_at(c + N, K_RD, 8'h60, 4);
    expect_at(c + N + 1, K_RD, 8'h28, 5);    // R5 flags after init
    expect_at(c + N + 1, K_HREQ, 8'h01, 9);  // R9 one cycle later
    expect_at(c + N + 2, K_HREQ, 8'h00, 7);
    step(); idle(); tx_wr = 1'b1; rx_load = 1'b1;
    expect_at(c + 2, K_VIOL, 8'h01, 6);      // R6 access while busy
    step(); idle(); ctl_wr = 1'b1; ctl_wdata = 8'h01;
    expect_at(c + 3, K_RD, 8'h60, 6);        // R6 control write ignored
    step(); idle();
    wait_until(c + N + 3);

    // R10 transmit fill and drain
    step(); c = cyc; tx_wr = 1'b1;
    expect_at(c + 1, K_RD, 8'h20, 10);
    expect_at(c + 2, K_HREQ, 8'h01, 7);
    step(); idle(); step();
    c = cyc; tx_drain = 1'b1;
    expect_at(c + 1, K_RD, 8'h28, 10);
    expect_at(c + 2, K_HREQ, 8'h00, 7);
    step(); idle(); step();

    // R10 simultaneous write and drain
    c = cyc; tx_wr = 1'b1; tx_drain = 1'b1;
    expect_at(c + 1, K_RD, 8'h20, 10);
    step(); idle();

    // R7 receive side in interrupt use
    pulse_ctl(8'h01, c);
    expect_at(c + 1, K_RD, 8'h01, 2);
    expect_at(c + 2, K_HREQ, 8'h01, 7);
    step(); idle(); c = cyc; rx_load = 1'b1;
    expect_at(c + 1, K_RD, 8'h11, 10);
    expect_at(c + 2, K_HREQ, 8'h00, 7);
    step(); idle(); c = cyc; rx_load = 1'b1; rx_rd = 1'b1;
    expect_at(c + 1, K_RD, 8'h11, 10);       // R10 simultaneous load and read
    step(); idle(); c = cyc; rx_rd = 1'b1;
    expect_at(c + 1, K_RD, 8'h01, 10);
    expect_at(c + 2, K_HREQ, 8'h01, 7);
    step(); idle();

    // R3 conflicting write
    pulse_ctl(8'h24, c);
    expect_at(c + 1, K_RD, 8'h01, 3);
    expect_at(c + 1, K_CERR, 8'h01, 3);
    step(); idle();
    // R2 status and reserved bits not writable
    pulse_ctl(8'h99, c);
    expect_at(c + 1, K_RD, 8'h01, 2);
    step(); idle();

    // R8 DMA, host to device direction
    pulse_ctl(8'h06, c);
    expect_at(c + 1, K_RD, 8'h06, 2);
    expect_at(c + 2, K_HREQ, 8'h01, 8);
    step(); idle(); c = cyc; tx_drain = 1'b1;
    expect_at(c + 1, K_RD, 8'h0E, 8);
    expect_at(c + 2, K_HREQ, 8'h00, 8);
    step(); idle();
    // R8 DMA, device to host direction
    pulse_ctl(8'h04, c);
    expect_at(c + 1, K_RD, 8'h0C, 8);
    expect_at(c + 2, K_HREQ, 8'h01, 8);
    step(); idle(); c = cyc; rx_load = 1'b1;
    expect_at(c + 1, K_RD, 8'h1C, 8);
    expect_at(c + 2, K_HREQ, 8'h00, 8);
    step(); idle();
    c = cyc;
    expect_at(c + 1, K_VIOL, 8'h01, 6);      // R6 sticky
    expect_at(c + 1, K_CERR, 8'h01, 3);

    while (sb.size() > 0) step();
    step();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule